// File: doc/BRIEF.md
# Synchronized Clock Stop Controller

This block sits between the clock dividers of a clock generator and its output pins. It receives one CPU-class source clock and one PCI-class source clock, both as levels that are synchronous to the block clock `clk`. From these it produces one gated CPU clock and seven gated PCI clocks. Three active-low requests arrive asynchronously: CPU stop, PCI stop and power-down. Each passes through a two-flop synchronizer before it takes effect. Configuration bits supply per-output enables, per-PCI-output free-run overrides and a global tristate control.

Each gate changes state only while its source is low. A stopped output therefore rests at 0, and a restarted output always begins with a complete high phase. Power-down first parks every output low. Only then does it drop the oscillator and PLL enables. On wake-up, the outputs stay low until the oscillator reports that it is stable. A pair of monitor outputs flags any stop request that follows a release too soon: fewer than a set number of source cycles of run time.

Top module: `clk_stop_ctrl`

## Requirements
- R1: While `rst_n` is low, every gated clock output is 0, `osc_en` and `pll_en` are 1, and both short-run flags are 0.
- R2: A gated output is high only while its source is high. It rises only together with a rising source and falls only together with a falling source, so every high phase it emits has the full width of the source high phase.
- R3: After `cpu_stop_n` goes low, `cpu_clk` emits no high sample after 4 `cpu_src` periods. After `cpu_stop_n` returns high, `cpu_clk` rises within 4 `cpu_src` periods.
- R4: While `pci_stop_n` is low, each PCI output whose free-run bit is 0 is held at 0, and `cpu_clk` keeps following its source. After release, stopped PCI outputs rise again within 2 `pci_src` periods.
- R5: Bit i of `pci_free` set to 1 makes `pci_clk[i]` keep following `pci_src` while `pci_stop_n` is low.
- R6: `cpu_en` = 0 holds `cpu_clk` at 0, and `pci_en[i]` = 0 holds `pci_clk[i]` at 0. Enabled outputs keep running.
- R7: After `pwrdn_n` goes low, all gated outputs are 0 within 3 `cpu_src` periods. `osc_en` and `pll_en` go to 0 only in a cycle after every output has been parked at 0.
- R8: While powered down, changes on `cpu_stop_n` and `pci_stop_n` have no effect: the outputs stay 0 and `osc_en` stays 0.
- R9: After `pwrdn_n` returns high, `osc_en` and `pll_en` return to 1, and all outputs stay 0 until `osc_stable` is 1. After that, the outputs resume under the rule of R2.
- R10: `tri_all` = 1 drives `out_oe` to 0 (0 means high impedance) whatever the other controls are. `tri_all` = 0 gives `out_oe` = 1.
- R11: `cpu_short_run` pulses high for one cycle when a CPU stop request follows its release after fewer than `CPU_MIN_RUN` (100) rising edges of `cpu_src`. It stays 0 when the run lasted at least that long.
- R12: `pci_short_run` pulses high for one cycle when a PCI stop request follows its release after fewer than `PCI_MIN_RUN` (10) rising edges of `pci_src`. It stays 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; the sources and osc_stable are synchronous to it |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_src | input | 1 | Ungated CPU-class divided clock level |
| pci_src | input | 1 | Ungated PCI-class divided clock level |
| cpu_stop_n | input | 1 | Asynchronous active-low CPU stop request |
| pci_stop_n | input | 1 | Asynchronous active-low PCI stop request |
| pwrdn_n | input | 1 | Asynchronous active-low power-down request |
| osc_stable | input | 1 | Oscillator and PLL have settled after wake-up |
| cpu_en | input | 1 | CPU output enable; 0 forces the output low |
| pci_en | input | 7 | Per-PCI-output enable; bit i controls pci_clk[i] |
| pci_free | input | 7 | Per-PCI-output free-run; bit i = 1 ignores PCI stop |
| tri_all | input | 1 | Global tristate control |
| cpu_clk | output | 1 | Gated CPU clock |
| pci_clk | output | 7 | Gated PCI clocks |
| out_oe | output | 1 | Output driver enable for all clock pins; 0 = high impedance |
| osc_en | output | 1 | Crystal oscillator enable |
| pll_en | output | 1 | PLL/VCO enable |
| cpu_short_run | output | 1 | One-cycle flag: CPU stop came after too short a run |
| pci_short_run | output | 1 | One-cycle flag: PCI stop came after too short a run |

## Verification
The bound checker watches the edge alignment of every gated output against its source on every cycle, so any runt pulse or mid-phase cut is caught wherever it occurs. On every cycle it also checks that oscillator shutdown never overlaps a running output and that wake-up begins with all outputs quiet. The latency bounds for stop and power-down, the free-run and enable masks, the don't-care behaviour of the stop inputs while powered down, and the short-run flag thresholds all depend on particular stimulus sequences. Only the directed scenarios of the bench show them.

// File: rtl/clk_stop_pkg.sv
`timescale 1ns/1ps
// Shared types for the clock stop controller.
package clk_stop_pkg;

    // Power sequencing states: running, parking outputs, oscillator off, waking
    typedef enum logic [1:0] {
        PD_RUN  = 2'd0,
        PD_PARK = 2'd1,
        PD_OFF  = 2'd2,
        PD_WAKE = 2'd3
    } pd_state_e;

endpackage

// File: rtl/csc_sync.sv
`timescale 1ns/1ps
// Multi-bit, multi-stage level synchronizer.
// Assumes: each bit is an independent quasi-static level; no bus coherence
// is needed across bits. Reset loads RST_VAL, the inactive level.
module csc_sync #(
    parameter int                 WIDTH   = 3,
    parameter int                 STAGES  = 2,
    parameter logic [WIDTH-1:0]   RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stg [STAGES];

    // Shift the asynchronous levels through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/csc_clk_gate.sv
`timescale 1ns/1ps
// Glitch-free gate for one divided clock.
// The gate state may change only while the source level is low, so the
// output never starts or ends a high phase part-way through.
// Assumes: src is a level synchronous to clk with each phase >= 1 clk.
module csc_clk_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic src,
    input  logic want,
    output logic gate_on,
    output logic clk_out
);

    // Take the requested gate state only during the source low phase
    always_ff @(posedge clk) begin
        if (!rst_n)   gate_on <= 1'b0;
        else if (!src) gate_on <= want;
    end

    assign clk_out = src & gate_on;

endmodule

// File: rtl/csc_pd_seq.sv
`timescale 1ns/1ps
// Power-down sequencer.
// On a request it withdraws the run permission and waits for every gate to
// close before dropping the oscillator and PLL enables. On release it
// re-enables them and holds the outputs until the oscillator is stable.
// Assumes: pd_req is already synchronized; osc_stable is synchronous to clk.
module csc_pd_seq
    import clk_stop_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pd_req,
    input  logic all_parked,
    input  logic osc_stable,
    output logic run,
    output logic osc_en,
    output logic pll_en
);

    pd_state_e state, state_nx;

    // Advance the sequencing state
    always_ff @(posedge clk) begin
        if (!rst_n) state <= PD_RUN;
        else        state <= state_nx;
    end

    // Select the next state from request, parking and stability status
    always_comb begin
        state_nx = state;
        unique case (state)
            PD_RUN:  if (pd_req)      state_nx = PD_PARK;
            PD_PARK: if (all_parked)  state_nx = PD_OFF;
            PD_OFF:  if (!pd_req)     state_nx = PD_WAKE;
            PD_WAKE: if (pd_req)      state_nx = PD_PARK;
                     else if (osc_stable) state_nx = PD_RUN;
            default:                  state_nx = PD_RUN;
        endcase
    end

    assign run    = (state == PD_RUN);
    assign osc_en = (state != PD_OFF);
    assign pll_en = (state != PD_OFF);

endmodule

// File: rtl/csc_run_monitor.sv
`timescale 1ns/1ps
// Minimum-run monitor for one stop domain.
// Counts source rising edges since the last stop release and raises a
// one-cycle flag when a new stop request arrives before MIN_RUN edges.
// Assumes: stop_req is synchronized; src is a level synchronous to clk.
module csc_run_monitor #(
    parameter int MIN_RUN = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic src,
    input  logic stop_req,
    output logic short_flag
);

    localparam int CNT_W = $clog2(MIN_RUN + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MIN_RUN);

    logic             src_q;
    logic             req_q;
    logic             seen_release;
    logic [CNT_W-1:0] run_cnt;
    logic             src_rise;
    logic             req_rise;
    logic             req_fall;

    assign src_rise = src & ~src_q;
    assign req_rise = stop_req & ~req_q;
    assign req_fall = ~stop_req & req_q;

    // Track run length since release and flag early stop requests
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q        <= 1'b0;
            req_q        <= 1'b0;
            seen_release <= 1'b0;
            run_cnt      <= '0;
            short_flag   <= 1'b0;
        end else begin
            src_q      <= src;
            req_q      <= stop_req;
            short_flag <= req_rise & seen_release & (run_cnt < LIMIT);
            if (req_fall) begin
                run_cnt      <= '0;
                seen_release <= 1'b1;
            end else if (!stop_req && src_rise && run_cnt < LIMIT) begin
                run_cnt <= run_cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/clk_stop_ctrl.sv
`timescale 1ns/1ps
// Synchronized clock stop controller (top).
// Gates one CPU-class and N_PCI PCI-class divided clocks under asynchronous
// stop and power-down requests, per-output enables and PCI free-run bits.
// Assumes: cpu_src and pci_src are levels synchronous to clk whose phases
// each last at least one clk cycle; osc_stable is synchronous to clk.
module clk_stop_ctrl #(
    parameter int N_PCI       = 7,
    parameter int SYNC_STAGES = 2,
    parameter int CPU_MIN_RUN = 100,
    parameter int PCI_MIN_RUN = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpu_src,
    input  logic             pci_src,
    input  logic             cpu_stop_n,
    input  logic             pci_stop_n,
    input  logic             pwrdn_n,
    input  logic             osc_stable,
    input  logic             cpu_en,
    input  logic [N_PCI-1:0] pci_en,
    input  logic [N_PCI-1:0] pci_free,
    input  logic             tri_all,
    output logic             cpu_clk,
    output logic [N_PCI-1:0] pci_clk,
    output logic             out_oe,
    output logic             osc_en,
    output logic             pll_en,
    output logic             cpu_short_run,
    output logic             pci_short_run
);

    localparam int N_REQ = 3;

    logic [N_REQ-1:0] req_sync;
    logic             cpu_stop_req;
    logic             pci_stop_req;
    logic             pd_req;
    logic             run;
    logic             cpu_want;
    logic             cpu_gate_on;
    logic [N_PCI-1:0] pci_want;
    logic [N_PCI-1:0] pci_gate_on;
    logic             all_parked;

    // Bring the three asynchronous requests into the clk domain
    csc_sync #(
        .WIDTH   (N_REQ),
        .STAGES  (SYNC_STAGES),
        .RST_VAL ({N_REQ{1'b1}})
    ) u_req_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({cpu_stop_n, pci_stop_n, pwrdn_n}),
        .q     (req_sync)
    );

    assign cpu_stop_req = ~req_sync[2];
    assign pci_stop_req = ~req_sync[1];
    assign pd_req       = ~req_sync[0];

    // Power sequencing and run permission
    csc_pd_seq u_pd_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .pd_req     (pd_req),
        .all_parked (all_parked),
        .osc_stable (osc_stable),
        .run        (run),
        .osc_en     (osc_en),
        .pll_en     (pll_en)
    );

    // CPU output gate
    assign cpu_want = run & cpu_en & ~cpu_stop_req;

    csc_clk_gate u_cpu_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .src     (cpu_src),
        .want    (cpu_want),
        .gate_on (cpu_gate_on),
        .clk_out (cpu_clk)
    );

    // One gate per PCI output, each with its own free-run override
    for (genvar g = 0; g < N_PCI; g++) begin : g_pci
        assign pci_want[g] = run & pci_en[g] & (pci_free[g] | ~pci_stop_req);

        csc_clk_gate u_pci_gate (
            .clk     (clk),
            .rst_n   (rst_n),
            .src     (pci_src),
            .want    (pci_want[g]),
            .gate_on (pci_gate_on[g]),
            .clk_out (pci_clk[g])
        );
    end

    assign all_parked = ~cpu_gate_on & ~(|pci_gate_on);

    // Global driver enable
    assign out_oe = ~tri_all;

    // Minimum-run monitors for both stop domains
    csc_run_monitor #(.MIN_RUN(CPU_MIN_RUN)) u_cpu_mon (
        .clk        (clk),
        .rst_n      (rst_n),
        .src        (cpu_src),
        .stop_req   (cpu_stop_req),
        .short_flag (cpu_short_run)
    );

    csc_run_monitor #(.MIN_RUN(PCI_MIN_RUN)) u_pci_mon (
        .clk        (clk),
        .rst_n      (rst_n),
        .src        (pci_src),
        .stop_req   (pci_stop_req),
        .short_flag (pci_short_run)
    );

endmodule

// File: rtl/clk_stop_ctrl_chk.sv
`timescale 1ns/1ps
// Property checker for clk_stop_ctrl, attached with bind below.
// Checks edge alignment of each gated output with its source and the
// ordering of oscillator shutdown and wake-up against the outputs.
module clk_stop_ctrl_chk #(
    parameter int N_PCI = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cpu_src,
    input logic             pci_src,
    input logic             cpu_clk,
    input logic [N_PCI-1:0] pci_clk,
    input logic             osc_en,
    input logic             pll_en
);

    // R2: CPU output edges coincide with source edges
    a_r2_cpu_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_clk) |-> $rose(cpu_src));
    a_r2_cpu_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cpu_clk) |-> $fell(cpu_src));

    // R2: each PCI output edge coincides with a source edge
    for (genvar g = 0; g < N_PCI; g++) begin : g_pci_chk
        a_r2_pci_rise: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(pci_clk[g]) |-> $rose(pci_src));
        a_r2_pci_fall: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(pci_clk[g]) |-> $fell(pci_src));
    end

    // R7: with the oscillator or PLL off, no output is running
    a_r7_osc_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_en |-> (!cpu_clk && pci_clk == '0));
    a_r7_pll_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !pll_en |-> (!cpu_clk && pci_clk == '0));

    // R7: shutdown only follows a cycle in which all outputs were parked
    a_r7_park_before_off: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(osc_en) |-> $past(!cpu_clk && pci_clk == '0));

    // R9: wake-up starts with every output quiet
    a_r9_wake_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(osc_en) |-> (!cpu_clk && pci_clk == '0));

endmodule

bind clk_stop_ctrl clk_stop_ctrl_chk #(.N_PCI(N_PCI)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cpu_src (cpu_src),
    .pci_src (pci_src),
    .cpu_clk (cpu_clk),
    .pci_clk (pci_clk),
    .osc_en  (osc_en),
    .pll_en  (pll_en)
);

// File: tb/clk_stop_ctrl_tb.sv
`timescale 1ns/1ps
// Directed bench for clk_stop_ctrl: one task per scenario.
// cpu_src has a period of 4 clk (2 high), pci_src a period of 8 clk (4 high).
module clk_stop_ctrl_tb;

    localparam int N_PCI    = 7;
    localparam int WATCHDOG = 200000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [2:0]       ph = '0;
    logic             cpu_src, pci_src;
    logic             cpu_stop_n = 1'b1, pci_stop_n = 1'b1, pwrdn_n = 1'b1;
    logic             osc_stable = 1'b1;
    logic             cpu_en = 1'b1;
    logic [N_PCI-1:0] pci_en = '1;
    logic [N_PCI-1:0] pci_free = '0;
    logic             tri_all = 1'b0;
    logic             cpu_clk;
    logic [N_PCI-1:0] pci_clk;
    logic             out_oe, osc_en, pll_en, cpu_short_run, pci_short_run;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    clk_stop_ctrl #(.N_PCI(N_PCI), .SYNC_STAGES(2), .CPU_MIN_RUN(100),
                    .PCI_MIN_RUN(10)) u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_src(cpu_src), .pci_src(pci_src),
        .cpu_stop_n(cpu_stop_n), .pci_stop_n(pci_stop_n), .pwrdn_n(pwrdn_n),
        .osc_stable(osc_stable), .cpu_en(cpu_en), .pci_en(pci_en),
        .pci_free(pci_free), .tri_all(tri_all), .cpu_clk(cpu_clk),
        .pci_clk(pci_clk), .out_oe(out_oe), .osc_en(osc_en), .pll_en(pll_en),
        .cpu_short_run(cpu_short_run), .pci_short_run(pci_short_run)
    );

    always #4 clk = ~clk;

    // Divided source clocks, advanced away from the active edge
    always @(negedge clk) ph <= ph + 3'd1;
    assign cpu_src = ph[1];
    assign pci_src = ph[2];

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic settle();
        repeat (20) tick();
    endtask

    // Compare every output against its source masked by the expected gating
    task automatic window(input int n, input bit exp_cpu,
                          input logic [N_PCI-1:0] exp_pci, input string req);
        int err_c = 0;
        int err_p = 0;
        for (int i = 0; i < n; i++) begin
            tick();
            if (cpu_clk !== (exp_cpu & cpu_src)) err_c++;
            if (pci_clk !== (exp_pci & {N_PCI{pci_src}})) err_p++;
        end
        check(err_c == 0, req, "cpu_clk vs gated source, bad samples", err_c, 0);
        check(err_p == 0, req, "pci_clk vs gated source, bad samples", err_p, 0);
    endtask

    // Count short-run flag pulses over a short interval
    task automatic watch_flags(input int n, output int cf, output int pf);
        cf = 0;
        pf = 0;
        for (int i = 0; i < n; i++) begin
            tick();
            if (cpu_short_run) cf++;
            if (pci_short_run) pf++;
        end
    endtask

    task automatic t_reset();
        repeat (4) tick();
        check(cpu_clk == 1'b0, "R1", "cpu_clk in reset", cpu_clk, 0);
        check(pci_clk == '0, "R1", "pci_clk in reset", pci_clk, 0);
        check(osc_en && pll_en, "R1", "osc_en&pll_en in reset", osc_en & pll_en, 1);
        check(!cpu_short_run && !pci_short_run, "R1", "flags in reset",
              cpu_short_run | pci_short_run, 0);
        @(negedge clk) rst_n = 1'b1;
    endtask

    task automatic t_run();
        settle();
        window(40, 1'b1, '1, "R2");
    endtask

    task automatic t_cpu_stop();
        int last_hi = -1;
        int first   = -1;
        int full    = 0;
        @(negedge clk) cpu_stop_n = 1'b0;
        for (int i = 0; i < 40; i++) begin
            tick();
            if (cpu_clk) last_hi = i;
        end
        check(last_hi < 16, "R3", "cpu off latency, last high sample", last_hi, 15);
        window(32, 1'b0, '1, "R3");
        @(negedge clk) cpu_stop_n = 1'b1;
        for (int i = 0; i < 40; i++) begin
            tick();
            if (cpu_clk && first < 0) first = i;
            if (first >= 0 && i == first + 1) full = cpu_clk;
        end
        check(first >= 0 && first < 16, "R3", "cpu on latency", first, 15);
        check(full == 1, "R2", "first restart pulse full width", full, 1);
        window(32, 1'b1, '1, "R2");
    endtask

    task automatic t_pci_stop();
        int last_hi = -1;
        int first   = -1;
        pci_free = 7'b0010101;
        @(negedge clk) pci_stop_n = 1'b0;
        for (int i = 0; i < 40; i++) begin
            tick();
            if (pci_clk[1]) last_hi = i;
        end
        check(last_hi < 16, "R4", "pci off latency", last_hi, 15);
        window(40, 1'b1, 7'b0010101, "R4 R5");
        @(negedge clk) pci_stop_n = 1'b1;
        for (int i = 0; i < 40; i++) begin
            tick();
            if (pci_clk[1] && first < 0) first = i;
        end
        check(first >= 0 && first < 16, "R4", "pci on latency", first, 15);
        window(40, 1'b1, '1, "R4");
        pci_free = '0;
    endtask

    task automatic t_enables();
        @(negedge clk);
        cpu_en = 1'b0;
        pci_en = 7'b1011011;
        settle();
        window(40, 1'b0, 7'b1011011, "R6");
        @(negedge clk);
        cpu_en = 1'b1;
        pci_en = '1;
        settle();
        window(24, 1'b1, '1, "R6");
    endtask

    task automatic t_tristate();
        @(negedge clk);
        tri_all = 1'b1;
        cpu_en  = 1'b0;
        tick();
        check(out_oe == 1'b0, "R10", "out_oe with tri_all=1", out_oe, 0);
        @(negedge clk) cpu_en = 1'b1;
        tick();
        check(out_oe == 1'b0, "R10", "out_oe with tri_all=1, cpu_en=1", out_oe, 0);
        @(negedge clk) tri_all = 1'b0;
        tick();
        check(out_oe == 1'b1, "R10", "out_oe with tri_all=0", out_oe, 1);
    endtask

    task automatic t_powerdown();
        int last_hi = -1;
        int off_at  = -1;
        int prev_q  = 0;
        int off_ok  = 0;
        int osc_hi  = 0;
        int out_hi  = 0;
        int first   = -1;
        @(negedge clk) pwrdn_n = 1'b0;
        for (int i = 0; i < 80; i++) begin
            tick();
            if (cpu_clk || pci_clk != '0) last_hi = i;
            if (!osc_en && off_at < 0) begin
                off_at = i;
                off_ok = prev_q;
            end
            if (off_at >= 0 && off_at != i && osc_en) osc_hi++;
            if (off_at >= 0 && (cpu_clk || pci_clk != '0)) out_hi++;
            prev_q = (!cpu_clk && pci_clk == '0) ? 1 : 0;
            if (i == 30) cpu_stop_n = 1'b0;
            if (i == 40) pci_stop_n = 1'b0;
            if (i == 55) cpu_stop_n = 1'b1;
            if (i == 65) pci_stop_n = 1'b1;
        end
        check(last_hi < 12, "R7", "last output high after power-down", last_hi, 11);
        check(off_at > last_hi, "R7", "osc off index after parking", off_at, last_hi + 1);
        check(off_ok == 1, "R7", "outputs parked before osc off", off_ok, 1);
        check(pll_en == 1'b0, "R7", "pll_en while powered down", pll_en, 0);
        check(osc_hi == 0, "R8", "osc_en highs during stop toggling", osc_hi, 0);
        check(out_hi == 0, "R8", "output highs during stop toggling", out_hi, 0);
        @(negedge clk);
        osc_stable = 1'b0;
        pwrdn_n    = 1'b1;
        out_hi     = 0;
        for (int i = 0; i < 40; i++) begin
            tick();
            if (cpu_clk || pci_clk != '0) out_hi++;
        end
        check(osc_en && pll_en, "R9", "enables back on after wake", osc_en & pll_en, 1);
        check(out_hi == 0, "R9", "output highs before osc_stable", out_hi, 0);
        @(negedge clk) osc_stable = 1'b1;
        for (int i = 0; i < 20; i++) begin
            tick();
            if (cpu_clk && first < 0) first = i;
        end
        check(first >= 0 && first < 12, "R9", "cpu resume after osc_stable", first, 11);
        window(32, 1'b1, '1, "R9");
    endtask

    task automatic t_short_run();
        int cf, pf;
        repeat (480) tick();
        @(negedge clk) cpu_stop_n = 1'b0;
        watch_flags(12, cf, pf);
        check(cf == 0, "R11", "cpu flag after long run", cf, 0);
        @(negedge clk) cpu_stop_n = 1'b1;
        repeat (80) tick();
        @(negedge clk) cpu_stop_n = 1'b0;
        watch_flags(12, cf, pf);
        check(cf == 1, "R11", "cpu flag after short run", cf, 1);
        @(negedge clk) cpu_stop_n = 1'b1;
        repeat (120) tick();
        @(negedge clk) pci_stop_n = 1'b0;
        watch_flags(12, cf, pf);
        check(pf == 0, "R12", "pci flag after long run", pf, 0);
        @(negedge clk) pci_stop_n = 1'b1;
        repeat (24) tick();
        @(negedge clk) pci_stop_n = 1'b0;
        watch_flags(12, cf, pf);
        check(pf == 1, "R12", "pci flag after short run", pf, 1);
        @(negedge clk) pci_stop_n = 1'b1;
    endtask

    initial begin
        t_reset();
        t_run();
        t_cpu_stop();
        t_pci_stop();
        t_enables();
        t_tristate();
        t_powerdown();
        t_short_run();
        done = 1;
        report();
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected completion", WATCHDOG);
            report();
            $finish;
        end
    end

endmodule